// File: doc/BRIEF.md
# Transactional Line Cache Controller

A small, fully associative cache that gives one processor hardware support for memory transactions. Each line touched inside a transaction is held as two entries. The first keeps the value from before the transaction and is thrown away on commit. The second keeps the speculative value and is thrown away on abort. Ending a transaction only changes the tags of all entries at once, so commit and abort each take a single cycle whatever the number of lines touched.

The processor side sends one request at a time: transactional load, load-exclusive, store, commit, abort or validate. Each request gets one response pulse carrying a success bit and data. When a line is missing, the block issues a shared or ownership fetch on the bus. Before it reuses a dirty committed entry, it writes that entry back. When a fetch is answered with Busy, the open transaction is killed at once. Snooped fetches from other processors are answered Busy while this block holds the line reserved.

The controller has four states. IDLE accepts requests, serves hits and executes commit, abort and validate in place. FETCH holds a bus fetch until the reply. ALLOC places one entry per cycle in the victim slot. WRITEBACK drains a dirty victim before ALLOC reuses it. The transitions are:
- IDLE→FETCH on a miss.
- IDLE→ALLOC on a hit to a committed line.
- FETCH→ALLOC on an Ok reply.
- FETCH→IDLE on a Busy reply.
- ALLOC→WRITEBACK on a dirty committed victim.
- WRITEBACK→ALLOC on the bus reply.
- ALLOC→IDLE after the last entry is placed, or when no victim exists. In the no-victim case the transaction is aborted.

Top module: `txn_line_cache`

## Requirements
- R1: After reset, `req_ready` is 1, and `resp_valid`, `bus_req_valid` and `snoop_busy` are 0. The transaction flag reads true, and no bus request is made while `req_ready` is 1.
- R2: A load (op 0) to a line that is not held issues a shared fetch (kind 0). It responds with ok=1 and the fetched data.
- R3: A load-exclusive (op 1) or store (op 2) to a line that is not held issues an ownership fetch (kind 1).
- R4: A load to a line already held returns its current value without any bus request.
- R5: A store to a line held by the open transaction changes only the speculative copy. Later loads return the stored value, and the store response carries the stored value.
- R6: Abort (op 4) responds ok=1. It discards speculative values, so the pre-transaction value is served again without a bus request.
- R7: Commit (op 3) with the flag true responds ok=1. The speculative values become the committed ones, and later transactions read them without a bus request.
- R8: After a store or load-exclusive, a snoop to that line gets `snoop_busy`=1, and snoops to other lines get 0. After any commit or abort, no line is reserved.
- R9: A Busy reply to a fetch aborts the transaction and responds ok=0. Later loads and stores of that transaction respond ok=0 with no bus request, and its commit is refused with ok=0.
- R10: Validate (op 5) returns the transaction flag. An explicit abort clears the flag, and the first load or store after commit or abort starts a new transaction with the flag true.
- R11: A new entry takes an empty slot before a committed one. A dirty committed victim is first written back (kind 2) with its own address and data.
- R12: Commit, abort and validate respond in the cycle after acceptance, with `req_ready` high again.
- R13: A bus request keeps its kind and address stable until `bus_resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | 0 load, 1 load-exclusive, 2 store, 3 commit, 4 abort, 5 validate |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_ok | output | 1 | Success, or the flag for validate |
| resp_data | output | DATA_W | Load or stored value |
| bus_req_valid | output | 1 | Bus request held until reply |
| bus_req_kind | output | 2 | 0 shared fetch, 1 ownership fetch, 2 write-back |
| bus_req_addr | output | ADDR_W | Bus line address |
| bus_req_data | output | DATA_W | Write-back data |
| bus_resp_valid | input | 1 | Bus reply |
| bus_resp_busy | input | 1 | Reply is Busy |
| bus_resp_data | input | DATA_W | Fetched data |
| snoop_valid | input | 1 | Foreign fetch snooped |
| snoop_addr | input | ADDR_W | Snooped line address |
| snoop_busy | output | 1 | Line reserved here |

## Verification
The main function is driven with load, store and load-exclusive sequences that hit speculative entries, hit committed entries and miss, each closed by commit or by abort. Comparing the later read value and the bus-request counts separates a committed value from a restored one, and a hit from a refetch. A reply from a Busy address region shows whether the kill path drops speculative data and refuses the commit. A four-entry configuration is filled so that victim choice and write-back become visible at the bus. A sweep of store/commit/reload rounds over eight lines cycles the slots through every tag.

// File: rtl/txc_pkg.sv
package txc_pkg;
    typedef enum logic [1:0] {
        TAG_EMPTY   = 2'd0,
        TAG_NORMAL  = 2'd1,
        TAG_XCOMMIT = 2'd2,
        TAG_XABORT  = 2'd3
    } tag_t;

    localparam logic [2:0] OP_LT       = 3'd0;
    localparam logic [2:0] OP_LTX      = 3'd1;
    localparam logic [2:0] OP_ST       = 3'd2;
    localparam logic [2:0] OP_COMMIT   = 3'd3;
    localparam logic [2:0] OP_ABORT    = 3'd4;
    localparam logic [2:0] OP_VALIDATE = 3'd5;

    localparam logic [1:0] BUS_TREAD = 2'd0;
    localparam logic [1:0] BUS_TRFO  = 2'd1;
    localparam logic [1:0] BUS_WB    = 2'd2;
endpackage

// File: rtl/txc_match.sv
module txc_match
    import txc_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int ADDR_W      = 32,
    localparam int IW         = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  tag_t              tags  [NUM_ENTRIES],
    input  logic [ADDR_W-1:0] addrs [NUM_ENTRIES],
    input  logic [ADDR_W-1:0] key,
    output logic              xa_hit,
    output logic [IW-1:0]     xa_idx,
    output logic              nm_hit,
    output logic [IW-1:0]     nm_idx
);
    logic [NUM_ENTRIES-1:0] xa_vec;
    logic [NUM_ENTRIES-1:0] nm_vec;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        assign xa_vec[g] = (tags[g] == TAG_XABORT) && (addrs[g] == key);
        assign nm_vec[g] = (tags[g] == TAG_NORMAL) && (addrs[g] == key);
    end

    always_comb begin
        xa_hit = |xa_vec;
        nm_hit = |nm_vec;
        xa_idx = '0;
        nm_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (xa_vec[i]) xa_idx = IW'(i);
            if (nm_vec[i]) nm_idx = IW'(i);
        end
    end
endmodule

// File: rtl/txc_victim.sv
module txc_victim
    import txc_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    localparam int IW         = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  tag_t          tags [NUM_ENTRIES],
    input  logic          skip_en,
    input  logic [IW-1:0] skip_idx,
    output logic          found,
    output logic [IW-1:0] idx,
    output tag_t          vtag
);
    logic [NUM_ENTRIES-1:0] is_empty, is_norm, is_xc;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cls
        logic skip_me;
        assign skip_me     = skip_en && (skip_idx == IW'(g));
        assign is_empty[g] = (tags[g] == TAG_EMPTY);
        assign is_norm[g]  = (tags[g] == TAG_NORMAL);
        assign is_xc[g]    = (tags[g] == TAG_XCOMMIT) && !skip_me;
    end

    always_comb begin
        logic [NUM_ENTRIES-1:0] pick;
        if (|is_empty)     pick = is_empty;
        else if (|is_norm) pick = is_norm;
        else               pick = is_xc;
        found = |pick;
        idx   = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--)
            if (pick[i]) idx = IW'(i);
        vtag = tags[idx];
    end
endmodule

// File: rtl/txc_snoop.sv
module txc_snoop
    import txc_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int ADDR_W      = 32
) (
    input  tag_t                   tags  [NUM_ENTRIES],
    input  logic [ADDR_W-1:0]      addrs [NUM_ENTRIES],
    input  logic [NUM_ENTRIES-1:0] rsv,
    input  logic                   snoop_valid,
    input  logic [ADDR_W-1:0]      snoop_addr,
    output logic                   busy
);
    logic [NUM_ENTRIES-1:0] hold;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_hold
        assign hold[g] = rsv[g] && (tags[g] == TAG_XABORT) && (addrs[g] == snoop_addr);
    end

    assign busy = snoop_valid && (|hold);
endmodule

// File: rtl/txn_line_cache.sv
module txn_line_cache
    import txc_pkg::*;
#(
    parameter int NUM_ENTRIES = 64,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_ok,
    output logic [DATA_W-1:0] resp_data,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_kind,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_data,
    input  logic              bus_resp_valid,
    input  logic              bus_resp_busy,
    input  logic [DATA_W-1:0] bus_resp_data,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_busy
);
    localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    typedef enum logic [1:0] {S_IDLE, S_FETCH, S_ALLOC, S_WB} state_t;

    state_t                 state_q, state_d;
    tag_t                   tag_q  [NUM_ENTRIES];
    logic [ADDR_W-1:0]      addr_q [NUM_ENTRIES];
    logic [DATA_W-1:0]      data_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] dirty_q, rsv_q;
    logic                   in_txn_q, status_q;

    logic [2:0]        op_r;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] wdata_r, xc_data_r, xa_data_r, ld_data_r;
    logic              xc_dirty_r, xa_dirty_r;
    logic              step_q, last_q;
    logic [IW-1:0]     prev_idx_q;

    logic              resp_valid_q, resp_ok_q;
    logic [DATA_W-1:0] resp_data_q;

    logic          hit_xa, hit_nm;
    logic [IW-1:0] idx_xa, idx_nm;
    logic          vic_found;
    logic [IW-1:0] vic_idx;
    tag_t          vic_tag;

    logic mem_op, eff_status, retag_commit, retag_abort, vic_needs_wb;

    txc_match #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .tags(tag_q), .addrs(addr_q), .key(req_addr),
        .xa_hit(hit_xa), .xa_idx(idx_xa), .nm_hit(hit_nm), .nm_idx(idx_nm)
    );

    txc_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
        .tags(tag_q), .skip_en(step_q), .skip_idx(prev_idx_q),
        .found(vic_found), .idx(vic_idx), .vtag(vic_tag)
    );

    txc_snoop #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_snoop (
        .tags(tag_q), .addrs(addr_q), .rsv(rsv_q),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .busy(snoop_busy)
    );

    assign mem_op       = (req_op == OP_LT) || (req_op == OP_LTX) || (req_op == OP_ST);
    assign eff_status   = in_txn_q ? status_q : 1'b1;
    assign vic_needs_wb = (vic_tag == TAG_NORMAL) && dirty_q[vic_idx];

    // next state and retag strobes
    always_comb begin
        state_d      = state_q;
        retag_commit = 1'b0;
        retag_abort  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (req_op == OP_COMMIT) begin
                        retag_commit = status_q;
                        retag_abort  = !status_q;
                    end else if (req_op == OP_ABORT) begin
                        retag_abort = 1'b1;
                    end else if (mem_op && eff_status && !hit_xa) begin
                        state_d = hit_nm ? S_ALLOC : S_FETCH;
                    end
                end
            end
            S_FETCH: begin
                if (bus_resp_valid) begin
                    retag_abort = bus_resp_busy;
                    state_d     = bus_resp_busy ? S_IDLE : S_ALLOC;
                end
            end
            S_ALLOC: begin
                if (!vic_found) begin
                    retag_abort = 1'b1;
                    state_d     = S_IDLE;
                end else if (vic_needs_wb) begin
                    state_d = S_WB;
                end else if (step_q == last_q) begin
                    state_d = S_IDLE;
                end
            end
            S_WB: begin
                if (bus_resp_valid) state_d = S_ALLOC;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // entry storage, transaction flag and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) begin
                tag_q[i]  <= TAG_EMPTY;
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
            dirty_q      <= '0;
            rsv_q        <= '0;
            in_txn_q     <= 1'b0;
            status_q     <= 1'b1;
            op_r         <= OP_LT;
            addr_r       <= '0;
            wdata_r      <= '0;
            xc_data_r    <= '0;
            xa_data_r    <= '0;
            ld_data_r    <= '0;
            xc_dirty_r   <= 1'b0;
            xa_dirty_r   <= 1'b0;
            step_q       <= 1'b0;
            last_q       <= 1'b0;
            prev_idx_q   <= '0;
            resp_valid_q <= 1'b0;
            resp_ok_q    <= 1'b0;
            resp_data_q  <= '0;
        end else begin
            resp_valid_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        resp_data_q <= '0;
                        if (req_op == OP_VALIDATE) begin
                            resp_valid_q <= 1'b1;
                            resp_ok_q    <= status_q;
                        end else if (req_op == OP_ABORT) begin
                            resp_valid_q <= 1'b1;
                            resp_ok_q    <= 1'b1;
                            status_q     <= 1'b0;
                            in_txn_q     <= 1'b0;
                        end else if (req_op == OP_COMMIT) begin
                            resp_valid_q <= 1'b1;
                            resp_ok_q    <= status_q;
                            in_txn_q     <= 1'b0;
                        end else if (!mem_op) begin
                            resp_valid_q <= 1'b1;
                            resp_ok_q    <= 1'b0;
                        end else begin
                            op_r    <= req_op;
                            addr_r  <= req_addr;
                            wdata_r <= req_wdata;
                            step_q  <= 1'b0;
                            if (!in_txn_q) begin
                                in_txn_q <= 1'b1;
                                status_q <= 1'b1;
                            end
                            if (!eff_status) begin
                                resp_valid_q <= 1'b1;
                                resp_ok_q    <= 1'b0;
                            end else if (hit_xa) begin
                                resp_valid_q <= 1'b1;
                                resp_ok_q    <= 1'b1;
                                resp_data_q  <= (req_op == OP_ST) ? req_wdata : data_q[idx_xa];
                                if (req_op == OP_ST) begin
                                    data_q[idx_xa]  <= req_wdata;
                                    dirty_q[idx_xa] <= 1'b1;
                                end
                                if (req_op != OP_LT) rsv_q[idx_xa] <= 1'b1;
                            end else if (hit_nm) begin
                                tag_q[idx_nm] <= TAG_XABORT;
                                rsv_q[idx_nm] <= (req_op != OP_LT);
                                xc_data_r     <= data_q[idx_nm];
                                xc_dirty_r    <= dirty_q[idx_nm];
                                ld_data_r     <= (req_op == OP_ST) ? req_wdata : data_q[idx_nm];
                                last_q        <= 1'b0;
                                if (req_op == OP_ST) begin
                                    data_q[idx_nm]  <= req_wdata;
                                    dirty_q[idx_nm] <= 1'b1;
                                end
                            end else begin
                                last_q <= 1'b1;
                            end
                        end
                    end
                end
                S_FETCH: begin
                    if (bus_resp_valid) begin
                        if (bus_resp_busy) begin
                            status_q     <= 1'b0;
                            resp_valid_q <= 1'b1;
                            resp_ok_q    <= 1'b0;
                            resp_data_q  <= '0;
                        end else begin
                            xc_data_r  <= bus_resp_data;
                            xc_dirty_r <= 1'b0;
                            xa_data_r  <= (op_r == OP_ST) ? wdata_r : bus_resp_data;
                            xa_dirty_r <= (op_r == OP_ST);
                            ld_data_r  <= (op_r == OP_ST) ? wdata_r : bus_resp_data;
                        end
                    end
                end
                S_ALLOC: begin
                    if (!vic_found) begin
                        status_q     <= 1'b0;
                        resp_valid_q <= 1'b1;
                        resp_ok_q    <= 1'b0;
                        resp_data_q  <= '0;
                    end else if (!vic_needs_wb) begin
                        tag_q[vic_idx]   <= step_q ? TAG_XABORT : TAG_XCOMMIT;
                        addr_q[vic_idx]  <= addr_r;
                        data_q[vic_idx]  <= step_q ? xa_data_r : xc_data_r;
                        dirty_q[vic_idx] <= step_q ? xa_dirty_r : xc_dirty_r;
                        rsv_q[vic_idx]   <= step_q && (op_r != OP_LT);
                        prev_idx_q       <= vic_idx;
                        if (step_q == last_q) begin
                            resp_valid_q <= 1'b1;
                            resp_ok_q    <= 1'b1;
                            resp_data_q  <= ld_data_r;
                            step_q       <= 1'b0;
                        end else begin
                            step_q <= 1'b1;
                        end
                    end
                end
                S_WB: begin
                    if (bus_resp_valid) dirty_q[vic_idx] <= 1'b0;
                end
                default: ;
            endcase

            if (retag_commit || retag_abort) begin
                rsv_q <= '0;
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    if (tag_q[i] == TAG_XCOMMIT)
                        tag_q[i] <= retag_commit ? TAG_EMPTY : TAG_NORMAL;
                    else if (tag_q[i] == TAG_XABORT)
                        tag_q[i] <= retag_commit ? TAG_NORMAL : TAG_EMPTY;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == S_IDLE);
        bus_req_valid = 1'b0;
        bus_req_kind  = BUS_TREAD;
        bus_req_addr  = addr_r;
        bus_req_data  = '0;
        unique case (state_q)
            S_FETCH: begin
                bus_req_valid = 1'b1;
                bus_req_kind  = (op_r == OP_LT) ? BUS_TREAD : BUS_TRFO;
            end
            S_WB: begin
                bus_req_valid = 1'b1;
                bus_req_kind  = BUS_WB;
                bus_req_addr  = addr_q[vic_idx];
                bus_req_data  = data_q[vic_idx];
            end
            default: ;
        endcase
        resp_valid = resp_valid_q;
        resp_ok    = resp_ok_q;
        resp_data  = resp_data_q;
    end
endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic              resp_valid,
    input logic              resp_ok,
    input logic              bus_req_valid,
    input logic [1:0]        bus_req_kind,
    input logic [ADDR_W-1:0] bus_req_addr,
    input logic              bus_resp_valid,
    input logic              bus_resp_busy,
    input logic              snoop_busy
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_req_valid);

    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_resp_valid) |=>
            (bus_req_valid && $stable(bus_req_kind) && $stable(bus_req_addr)));

    p_busy_kills_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_resp_valid && bus_resp_busy && bus_req_kind != 2'd2) |=>
            (resp_valid && !resp_ok));

    p_quick_ops_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 3'd3 || req_op == 3'd4 || req_op == 3'd5)) |=>
            (resp_valid && req_ready));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 3'd3 || req_op == 3'd4)) |=> !snoop_busy);
endmodule

bind txn_line_cache txc_checker #(.ADDR_W(ADDR_W)) u_txc_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .resp_valid(resp_valid), .resp_ok(resp_ok),
    .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
    .bus_req_addr(bus_req_addr), .bus_resp_valid(bus_resp_valid),
    .bus_resp_busy(bus_resp_busy), .snoop_busy(snoop_busy)
);

// File: tb/test_txn_line_cache.sv
`timescale 1ns/1ps
module test_txn_line_cache;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic resp_valid, resp_ok;
    logic [DW-1:0] resp_data;
    logic bus_req_valid;
    logic [1:0] bus_req_kind;
    logic [AW-1:0] bus_req_addr;
    logic [DW-1:0] bus_req_data;
    logic bus_resp_valid = 1'b0;
    logic bus_resp_busy = 1'b0;
    logic [DW-1:0] bus_resp_data = '0;
    logic snoop_valid = 1'b0;
    logic [AW-1:0] snoop_addr = '0;
    logic snoop_busy;

    int n_checks = 0;
    int n_err = 0;
    int n_tread = 0, n_trfo = 0, n_wb = 0;
    logic [AW-1:0] wb_addr = '0;
    logic [DW-1:0] wb_data = '0;
    int rcnt = 0;
    logic got_ok;
    logic [DW-1:0] got_data;

    always #2 clk = ~clk;

    txn_line_cache #(.NUM_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) i_txn_line_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_ok(resp_ok), .resp_data(resp_data),
        .bus_req_valid(bus_req_valid), .bus_req_kind(bus_req_kind),
        .bus_req_addr(bus_req_addr), .bus_req_data(bus_req_data),
        .bus_resp_valid(bus_resp_valid), .bus_resp_busy(bus_resp_busy),
        .bus_resp_data(bus_resp_data), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .snoop_busy(snoop_busy)
    );

    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        return {a, a ^ 8'h5A};
    endfunction

    // bus responder: reply two cycles after a request appears
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_resp_valid <= 1'b0;
            rcnt <= 0;
        end else if (bus_resp_valid) begin
            bus_resp_valid <= 1'b0;
            rcnt <= 0;
        end else if (bus_req_valid) begin
            if (rcnt == 1) begin
                bus_resp_valid <= 1'b1;
                bus_resp_busy  <= (bus_req_kind != 2'd2) && (bus_req_addr[7:4] == 4'hF);
                bus_resp_data  <= memval(bus_req_addr);
                if (bus_req_kind == 2'd0) n_tread <= n_tread + 1;
                if (bus_req_kind == 2'd1) n_trfo  <= n_trfo + 1;
                if (bus_req_kind == 2'd2) begin
                    n_wb    <= n_wb + 1;
                    wb_addr <= bus_req_addr;
                    wb_data <= bus_req_data;
                end
            end
            rcnt <= rcnt + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        got_ok   = resp_ok;
        got_data = resp_data;
    endtask

    task automatic snoop(input logic [AW-1:0] a, output logic b);
        @(negedge clk);
        snoop_valid = 1'b1;
        snoop_addr  = a;
        #1 b = snoop_busy;
        snoop_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int b0;
        logic sb;
        do_reset();
        @(negedge clk);
        chk("R1 reset outputs", {req_ready, resp_valid, bus_req_valid, snoop_busy}, 4'b1000);
        do_req(3'd5, 8'h00, 16'h0);
        chk("R1 flag true after reset", got_ok, 1);

        b0 = n_tread;
        do_req(3'd0, 8'h10, 16'h0);
        chk("R2 load miss ok", got_ok, 1);
        chk("R2 load miss data", got_data, memval(8'h10));
        chk("R2 shared fetch issued", n_tread, b0 + 1);

        b0 = n_tread + n_trfo;
        do_req(3'd0, 8'h10, 16'h0);
        chk("R4 hit data", got_data, memval(8'h10));
        do_req(3'd2, 8'h10, 16'hBEEF);
        chk("R5 store resp data", got_data, 16'hBEEF);
        do_req(3'd0, 8'h10, 16'h0);
        chk("R5 load sees store", got_data, 16'hBEEF);
        chk("R4 no bus on hits", n_tread + n_trfo, b0);

        snoop(8'h10, sb);
        chk("R8 reserved line busy", sb, 1);
        snoop(8'h11, sb);
        chk("R8 other line free", sb, 0);

        do_req(3'd4, 8'h00, 16'h0);
        chk("R6 abort ok", got_ok, 1);
        snoop(8'h10, sb);
        chk("R8 released by abort", sb, 0);
        do_req(3'd5, 8'h00, 16'h0);
        chk("R10 flag false after abort", got_ok, 0);

        b0 = n_tread + n_trfo;
        do_req(3'd0, 8'h10, 16'h0);
        chk("R6 old value restored", got_data, memval(8'h10));
        chk("R6 no refetch", n_tread + n_trfo, b0);
        do_req(3'd5, 8'h00, 16'h0);
        chk("R10 new txn flag true", got_ok, 1);

        b0 = n_trfo;
        do_req(3'd2, 8'h20, 16'h1234);
        chk("R3 store miss ownership fetch", n_trfo, b0 + 1);
        snoop(8'h20, sb);
        chk("R8 store reserves", sb, 1);
        do_req(3'd3, 8'h00, 16'h0);
        chk("R7 commit ok", got_ok, 1);
        snoop(8'h20, sb);
        chk("R8 released by commit", sb, 0);

        b0 = n_tread + n_trfo;
        do_req(3'd0, 8'h20, 16'h0);
        chk("R7 committed value", got_data, 16'h1234);
        chk("R7 no refetch", n_tread + n_trfo, b0);

        b0 = n_trfo;
        do_req(3'd1, 8'h30, 16'h0);
        chk("R3 ltx miss ownership fetch", n_trfo, b0 + 1);
        chk("R3 ltx data", got_data, memval(8'h30));
        snoop(8'h30, sb);
        chk("R8 ltx reserves", sb, 1);

        do_req(3'd0, 8'hF0, 16'h0);
        chk("R9 busy reply fails", got_ok, 0);
        do_req(3'd5, 8'h00, 16'h0);
        chk("R9 validate false", got_ok, 0);
        b0 = n_tread + n_trfo + n_wb;
        do_req(3'd0, 8'h40, 16'h0);
        chk("R9 dead txn load fails", got_ok, 0);
        chk("R9 dead txn no bus", n_tread + n_trfo + n_wb, b0);
        do_req(3'd3, 8'h00, 16'h0);
        chk("R9 commit refused", got_ok, 0);
        do_req(3'd0, 8'h20, 16'h0);
        chk("R9 prior commit survives", got_data, 16'h1234);
        do_req(3'd4, 8'h00, 16'h0);

        // victim selection and write-back on a fresh four-entry cache
        do_reset();
        do_req(3'd2, 8'h40, 16'hCAFE);
        do_req(3'd0, 8'h50, 16'h0);
        do_req(3'd3, 8'h00, 16'h0);
        b0 = n_wb;
        do_req(3'd0, 8'h60, 16'h0);
        chk("R11 empty slots used first", n_wb, b0);
        b0 = n_tread + n_trfo;
        do_req(3'd0, 8'h50, 16'h0);
        chk("R11 normal line kept", got_data, memval(8'h50));
        chk("R11 no refetch of kept line", n_tread + n_trfo, b0);
        chk("R11 dirty victim written back", n_wb, 1);
        chk("R11 write-back address", wb_addr, 8'h40);
        chk("R11 write-back data", wb_data, 16'hCAFE);
        do_req(3'd3, 8'h00, 16'h0);

        // sweep: store, commit, reload across eight lines
        for (int k = 0; k < 8; k++) begin
            do_req(3'd2, 8'h80 + 8'(k), 16'(k * 16'h111 + 1));
            do_req(3'd3, 8'h00, 16'h0);
            chk("R7 sweep commit", got_ok, 1);
            do_req(3'd0, 8'h80 + 8'(k), 16'h0);
            chk("R5 sweep reload", got_data, k * 16'h111 + 1);
            do_req(3'd3, 8'h00, 16'h0);
        end

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule